// File: doc/BRIEF.md
# Four-Register 8-bit Sequenced CPU Core

This block is a small multi-cycle processor core. It holds four 8-bit general registers, an 8-bit program counter, a carry flag and a shallow stack of return addresses. Instruction bytes arrive on an 8-bit input from an instruction store outside the block. The environment drives that input at the falling clock edge, addressed by the exposed program counter, and the core captures it at the next rising edge. Three strobes mark the phase the core is in: the first-byte fetch, the second-byte fetch and execution. The program counter, the carry flag and the phase code are brought out for observation.

An instruction is one byte in register form, or two bytes in immediate form, where the second byte is the immediate. The core supports addition and subtraction with carry and borrow, AND and XOR, an unconditional jump, a jump taken only when carry is set, a call that saves a return address, a return, and a no-operation. Undefined opcodes behave as a no-operation.

Top module: `quad_reg_cpu`

## Requirements
- R1: While reset (active high) is asserted, and after it is released, the PC reads 0, carry reads 0, all four registers hold 0, the return stack is empty and the phase code is 0 (first fetch).
- R2: The phase code is 0 in the first fetch, 1 in the second fetch and 2 in execute. Exactly one of the three strobes is high in each cycle. The second fetch is always followed by execute, and execute is always followed by the first fetch in the next cycle.
- R3: A first byte holds the opcode in bits [7:4], the destination register in [3:2] and the source register in [1:0]. Opcode codes are ADD=0, ADDI=1, SUB=2, SUBI=3, AND=4, ANDI=5, XOR=6, XORI=7, JMP=8, JMPC=9, CALL=10, RET=11 and NOP=12. Codes 1, 3, 5, 7, 8, 9 and 10 take a second fetch for the immediate byte. All other codes go directly to execute.
- R4: The PC changes only at the end of execute. A sequential instruction advances it by 1 in register form and by 2 in immediate form.
- R5: JMP loads the PC with the immediate.
- R6: JMPC loads the PC with the immediate when carry is 1. Otherwise it advances the PC by 2.
- R7: CALL pushes PC+2 and loads the PC with the immediate. RET loads the PC from the most recent pushed value and removes that value.
- R8: The return stack holds 4 entries. RET on an empty stack sets the PC to 0. CALL on a full stack discards the oldest entry.
- R9: ADD and ADDI write the 8-bit sum to the destination register and set carry to bit 8 of the sum. SUB and SUBI write the difference and set carry to 1 exactly when the destination value is below the operand. The operand is the source register in register form and the immediate in immediate form.
- R10: AND, ANDI, XOR and XORI write their result to the destination register and clear carry. Jumps, calls, returns and NOP leave carry and the registers unchanged.
- R11: NOP and the undefined codes 13 to 15 change only the PC, which advances by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the core acts on the rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| instr_byte | input | 8 | Instruction byte, driven at the falling edge |
| fetch1 | output | 1 | High during the first-byte fetch |
| fetch2 | output | 1 | High during the immediate-byte fetch |
| exec | output | 1 | High during execute |
| pc | output | 8 | Program counter |
| carry | output | 1 | Carry flag |
| phase | output | 2 | Phase code: 0 first fetch, 1 second fetch, 2 execute |

## Verification
The embedded properties check the following on every cycle: the phase strobes are one-hot and follow their order; the PC holds outside execute; a not-taken conditional jump adds exactly 2; a return lands on the stack's top entry; logic operations clear carry; and the stack count stays within bounds. Correct register arithmetic, write-back to the right destination and the oldest-entry discard on overflow are hidden inside the core. Only the bench's programs reveal them: a bench model tracks the same instruction stream and compares PC, carry and phase every cycle, and directed programs end in known PC and carry values.

// File: rtl/qrc_pkg.sv
package qrc_pkg;
  localparam int WORD_W = 8;
  localparam int NUM_REGS = 4;
  localparam int SEL_W = $clog2(NUM_REGS);
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 4'd0,  OP_ADDI = 4'd1,  OP_SUB  = 4'd2,  OP_SUBI = 4'd3,
    OP_AND  = 4'd4,  OP_ANDI = 4'd5,  OP_XOR  = 4'd6,  OP_XORI = 4'd7,
    OP_JMP  = 4'd8,  OP_JMPC = 4'd9,  OP_CALL = 4'd10, OP_RET  = 4'd11,
    OP_NOP  = 4'd12
  } opcode_t;

  typedef enum logic [1:0] {
    PH_FETCH1 = 2'd0,
    PH_FETCH2 = 2'd1,
    PH_EXEC   = 2'd2
  } phase_t;

  typedef struct packed {
    logic [WORD_W-1:0] val;
    logic              cout;
    logic              wr;
    logic              cupd;
  } alu_out_t;

  // Opcodes whose instruction carries a second (immediate) byte.
  function automatic logic needs_imm(input logic [OPC_W-1:0] code);
    case (code)
      OP_ADDI, OP_SUBI, OP_ANDI, OP_XORI, OP_JMP, OP_JMPC, OP_CALL: needs_imm = 1'b1;
      default: needs_imm = 1'b0;
    endcase
  endfunction

  // Datapath arithmetic; the result always targets the destination register.
  function automatic alu_out_t alu_eval(input logic [OPC_W-1:0] code,
                                        input logic [WORD_W-1:0] a,
                                        input logic [WORD_W-1:0] b);
    alu_out_t r;
    logic [WORD_W:0] wide;
    r = '0;
    wide = '0;
    case (code)
      OP_ADD, OP_ADDI: begin
        wide = {1'b0, a} + {1'b0, b};
        r.val = wide[WORD_W-1:0];
        r.cout = wide[WORD_W];
        r.wr = 1'b1;
        r.cupd = 1'b1;
      end
      OP_SUB, OP_SUBI: begin
        wide = {1'b0, a} - {1'b0, b};
        r.val = wide[WORD_W-1:0];
        r.cout = wide[WORD_W];
        r.wr = 1'b1;
        r.cupd = 1'b1;
      end
      OP_AND, OP_ANDI: begin
        r.val = a & b;
        r.wr = 1'b1;
        r.cupd = 1'b1;
      end
      OP_XOR, OP_XORI: begin
        r.val = a ^ b;
        r.wr = 1'b1;
        r.cupd = 1'b1;
      end
      default: r = '0;
    endcase
    alu_eval = r;
  endfunction
endpackage

// File: rtl/qrc_decode.sv
module qrc_decode
  import qrc_pkg::*;
(
  input  logic [WORD_W-1:0] ir,
  output logic [OPC_W-1:0]  code,
  output logic [SEL_W-1:0]  dst_sel,
  output logic [SEL_W-1:0]  src_sel,
  output logic              two_byte,
  output logic              is_logic,
  output logic              is_jmp,
  output logic              is_jmpc,
  output logic              is_call,
  output logic              is_ret
);
  always_comb begin
    code     = ir[WORD_W-1 -: OPC_W];
    dst_sel  = ir[2*SEL_W-1 -: SEL_W];
    src_sel  = ir[SEL_W-1:0];
    two_byte = needs_imm(code);
    is_logic = (code == OP_AND) || (code == OP_ANDI) ||
               (code == OP_XOR) || (code == OP_XORI);
    is_jmp   = (code == OP_JMP);
    is_jmpc  = (code == OP_JMPC);
    is_call  = (code == OP_CALL);
    is_ret   = (code == OP_RET);
  end
endmodule

// File: rtl/qrc_seq.sv
module qrc_seq
  import qrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  output phase_t            phase,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] imm,
  output logic              fetch1,
  output logic              fetch2,
  output logic              exec
);
  localparam logic [WORD_W-1:0] IDLE_IR = {OP_NOP, {(WORD_W-OPC_W){1'b0}}};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase <= PH_FETCH1;
      ir    <= IDLE_IR;
      imm   <= '0;
    end else begin
      case (phase)
        PH_FETCH1: begin
          ir    <= din;
          phase <= needs_imm(din[WORD_W-1 -: OPC_W]) ? PH_FETCH2 : PH_EXEC;
        end
        PH_FETCH2: begin
          imm   <= din;
          phase <= PH_EXEC;
        end
        default: phase <= PH_FETCH1;
      endcase
    end
  end

  assign fetch1 = (phase == PH_FETCH1);
  assign fetch2 = (phase == PH_FETCH2);
  assign exec   = (phase == PH_EXEC);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot({fetch1, fetch2, exec}));                 // R2
  AST_EXEC_THEN_FETCH1: assert property (@(posedge clk) disable iff (rst)
    exec |=> fetch1);                                 // R2
  AST_FETCH2_THEN_EXEC: assert property (@(posedge clk) disable iff (rst)
    fetch2 |=> exec);                                 // R2
endmodule

// File: rtl/qrc_ret_stack.sv
module qrc_ret_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val,
  output logic         empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     ent [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign empty = (cnt == '0);
  assign full  = (cnt == FULL_CNT);

  always_comb begin
    top_val = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i + 1) == cnt) top_val = ent[i];
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic load_here;
      logic shift_here;
      assign load_here  = push && ((!full && cnt == CNT_W'(g)) || (full && g == DEPTH - 1));
      assign shift_here = push && full && (g < DEPTH - 1);
      always_ff @(posedge clk or posedge rst) begin
        if (rst) ent[g] <= '0;
        else if (load_here) ent[g] <= push_val;
        else if (shift_here) ent[g] <= ent[(g + 1) % DEPTH];
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cnt <= '0;
    else if (push && !full) cnt <= cnt + 1'b1;
    else if (pop && !empty) cnt <= cnt - 1'b1;
  end

  AST_STK_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);                                                   // R8
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (cnt == $past(cnt) + 1'b1));                    // R7
  AST_FULL_PUSH_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> full);                                           // R8
endmodule

// File: rtl/quad_reg_cpu.sv
module quad_reg_cpu
  import qrc_pkg::*;
#(
  parameter int STACK_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  instr_byte,
  output logic        fetch1,
  output logic        fetch2,
  output logic        exec,
  output logic [7:0]  pc,
  output logic        carry,
  output logic [1:0]  phase
);
  phase_t            ph;
  logic [WORD_W-1:0] ir, imm;
  logic [OPC_W-1:0]  code;
  logic [SEL_W-1:0]  dst_sel, src_sel;
  logic              two_byte, is_logic, is_jmp, is_jmpc, is_call, is_ret;
  logic [WORD_W-1:0] regs [NUM_REGS];
  logic [WORD_W-1:0] pc_q, pc_next, pc_step, operand, stk_top;
  logic              carry_q, stk_empty, exec_fire, do_push, do_pop;
  alu_out_t          alu;

  qrc_seq u_seq (
    .clk(clk), .rst(rst), .din(instr_byte), .phase(ph), .ir(ir), .imm(imm),
    .fetch1(fetch1), .fetch2(fetch2), .exec(exec)
  );

  qrc_decode u_dec (
    .ir(ir), .code(code), .dst_sel(dst_sel), .src_sel(src_sel),
    .two_byte(two_byte), .is_logic(is_logic), .is_jmp(is_jmp),
    .is_jmpc(is_jmpc), .is_call(is_call), .is_ret(is_ret)
  );

  assign exec_fire = exec;
  assign do_push   = exec_fire && is_call;
  assign do_pop    = exec_fire && is_ret;
  assign pc_step   = pc_q + (two_byte ? WORD_W'(2) : WORD_W'(1));

  qrc_ret_stack #(.DEPTH(STACK_DEPTH), .W(WORD_W)) u_stk (
    .clk(clk), .rst(rst), .push(do_push), .pop(do_pop), .push_val(pc_step),
    .top_val(stk_top), .empty(stk_empty)
  );

  always_comb begin
    operand = two_byte ? imm : regs[src_sel];
    alu     = alu_eval(code, regs[dst_sel], operand);
  end

  always_comb begin
    pc_next = pc_step;
    if (is_jmp || is_call)      pc_next = imm;
    else if (is_jmpc && carry_q) pc_next = imm;
    else if (is_ret)             pc_next = stk_empty ? '0 : stk_top;
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic wr_en;
      assign wr_en = exec_fire && alu.wr && (dst_sel == SEL_W'(g));
      always_ff @(posedge clk or posedge rst) begin
        if (rst) regs[g] <= '0;
        else if (wr_en) regs[g] <= alu.val;
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pc_q    <= '0;
      carry_q <= 1'b0;
    end else if (exec_fire) begin
      pc_q <= pc_next;
      if (alu.cupd) carry_q <= alu.cout;
    end
  end

  assign pc    = pc_q;
  assign carry = carry_q;
  assign phase = ph;

  AST_PC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !exec |=> $stable(pc_q));                                           // R4
  AST_JMPC_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (exec && is_jmpc && !carry_q) |=> (pc_q == $past(pc_q) + 8'd2));    // R6
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
    (exec && is_ret && !stk_empty) |=> (pc_q == $past(stk_top)));       // R7
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (exec && is_logic) |=> !carry_q);                                   // R10
  AST_FLOW_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (exec && (is_jmp || is_jmpc || is_call || is_ret)) |=> $stable(carry_q)); // R10
endmodule

// File: tb/quad_reg_cpu_tb.sv
`timescale 1ns/1ps
module quad_reg_cpu_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] instr_byte = 8'hC0;
  logic       fetch1, fetch2, exec, carry;
  logic [7:0] pc;
  logic [1:0] phase;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_reg_cpu u_dut (
    .clk(clk), .rst(rst), .instr_byte(instr_byte), .fetch1(fetch1),
    .fetch2(fetch2), .exec(exec), .pc(pc), .carry(carry), .phase(phase)
  );

  logic [7:0] mem [256];

  // Behavioural reference model
  int m_st, m_pc, m_c, m_ir, m_imm;
  int m_r [4];
  int m_stk [$];
  string m_ptag = "R4";
  string m_ctag = "R9";

  function automatic bit is_two(int op);
    return op == 1 || op == 3 || op == 5 || op == 7 || op == 8 || op == 9 || op == 10;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_pc = 0; m_c = 0; m_ir = 8'hC0; m_imm = 0;
      foreach (m_r[i]) m_r[i] = 0;
      m_stk.delete();
    end else if (m_st == 0) begin
      m_ir = instr_byte;
      m_st = is_two(m_ir >> 4) ? 1 : 2;
    end else if (m_st == 1) begin
      m_imm = instr_byte;
      m_st = 2;
    end else begin
      int op, d, s, b, nxt;
      op = m_ir >> 4; d = (m_ir >> 2) & 3; s = m_ir & 3;
      b = is_two(op) ? m_imm : m_r[s];
      nxt = (m_pc + (is_two(op) ? 2 : 1)) % 256;
      m_ptag = "R4";
      case (op)
        0, 1: begin m_c = (m_r[d] + b) > 255; m_r[d] = (m_r[d] + b) % 256; m_ctag = "R9"; end
        2, 3: begin m_c = m_r[d] < b; m_r[d] = (m_r[d] - b + 256) % 256; m_ctag = "R9"; end
        4, 5: begin m_r[d] = m_r[d] & b; m_c = 0; m_ctag = "R10"; end
        6, 7: begin m_r[d] = m_r[d] ^ b; m_c = 0; m_ctag = "R10"; end
        8: begin nxt = m_imm; m_ptag = "R5"; end
        9: begin if (m_c != 0) nxt = m_imm; m_ptag = "R6"; end
        10: begin
          m_stk.push_back(nxt);
          if (m_stk.size() > 4) void'(m_stk.pop_front());
          nxt = m_imm; m_ptag = "R7";
        end
        11: begin
          if (m_stk.size() == 0) begin nxt = 0; m_ptag = "R8"; end
          else begin nxt = m_stk.pop_back(); m_ptag = "R7"; end
        end
        default: m_ptag = "R11";
      endcase
      m_pc = nxt;
      m_st = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare against the model every cycle, then drive the next byte.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(phase == m_st[1:0], "R2", "phase", phase, m_st);
      chk({fetch1, fetch2, exec} == (3'b100 >> m_st), "R2", "strobes", {fetch1, fetch2, exec}, 3'b100 >> m_st);
      chk(pc == m_pc[7:0], m_ptag, "pc", pc, m_pc);
      chk(carry == m_c[0], m_ctag, "carry", carry, m_c);
    end
    instr_byte = mem[(m_st == 1) ? ((m_pc + 1) % 256) : m_pc];
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'hC0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    clear_mem();
    // Reset state (R1)
    do_reset();
    chk(pc == 8'd0, "R1", "reset pc", pc, 0);
    chk(carry == 1'b0, "R1", "reset carry", carry, 0);
    chk(phase == 2'd0 && fetch1, "R1", "reset phase", phase, 0);

    // Arithmetic, carry and conditional jumps
    clear_mem();
    mem[0] = 8'h10; mem[1] = 8'hF0;   // ADDI r0,F0
    mem[2] = 8'h10; mem[3] = 8'h20;   // ADDI r0,20 -> carry
    mem[4] = 8'h90; mem[5] = 8'h08;   // JMPC 8 taken
    mem[6] = 8'h80; mem[7] = 8'h06;
    mem[8] = 8'h21;                   // SUB r0,r1
    mem[9] = 8'h90; mem[10] = 8'h00;  // JMPC not taken
    mem[11] = 8'h70; mem[12] = 8'h10; // XORI r0,10
    mem[13] = 8'h30; mem[14] = 8'h01; // SUBI r0,1 -> borrow
    mem[15] = 8'h80; mem[16] = 8'h0F; // JMP 15
    do_reset();
    run(60);
    chk(pc == 8'd15, "R5", "final pc (R6 path)", pc, 15);
    chk(carry == 1'b1, "R9", "borrow after zero", carry, 1);

    // Register forms, logic and undefined opcodes; immediate form takes fetch2
    clear_mem();
    mem[0] = 8'h14; mem[1] = 8'h81;   // ADDI r1,81
    mem[2] = 8'h05;                   // ADD r1,r1 -> carry
    mem[3] = 8'h46;                   // AND r1,r2
    mem[4] = 8'h6D;                   // XOR r3,r1
    mem[5] = 8'h34; mem[6] = 8'h01;   // SUBI r1,1
    mem[7] = 8'h54; mem[8] = 8'h0F;   // ANDI r1,0F
    mem[9] = 8'h29;                   // SUB r2,r1 -> borrow
    mem[10] = 8'hE3;                  // undefined
    mem[11] = 8'h80; mem[12] = 8'h0B; // JMP 11
    do_reset();
    run(1);
    chk(phase == 2'd1, "R3", "immediate form second fetch", phase, 1);
    run(60);
    chk(pc == 8'd11, "R11", "final pc", pc, 11);
    chk(carry == 1'b1, "R10", "carry kept by flow ops", carry, 1);

    // Call and return
    clear_mem();
    mem[0] = 8'hA0; mem[1] = 8'h04;
    mem[2] = 8'h80; mem[3] = 8'h02;
    mem[4] = 8'hA0; mem[5] = 8'h08;
    mem[6] = 8'hB0;
    mem[8] = 8'hB0;
    do_reset();
    run(40);
    chk(pc == 8'd2, "R7", "return chain", pc, 2);

    // Return on empty stack; register form goes straight to execute
    clear_mem();
    mem[0] = 8'hB0;
    do_reset();
    run(1);
    chk(phase == 2'd2, "R3", "register form exec", phase, 2);
    run(1);
    chk(pc == 8'd0 && phase == 2'd0, "R8", "empty return pc", pc, 0);

    // Stack overflow drops the oldest entry
    clear_mem();
    for (int i = 0; i < 5; i++) begin
      mem[2*i] = 8'hA0; mem[2*i+1] = 8'(2*i + 2);
    end
    mem[10] = 8'hB0; mem[11] = 8'hB0; mem[12] = 8'hB0;
    do_reset();
    run(120);

    // Random instruction streams checked by the model
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      do_reset();
      run(600);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule